// File: doc/BRIEF.md
# Guest-aware supervisor timer compare

This block keeps two 64-bit timer-compare values: one for the supervisor and one for a virtualized guest supervisor. Each value is compared on every clock against a time base. The supervisor value sees the raw time input. The guest value sees the time input plus a hypervisor-owned delta, and that sum wraps modulo 2^64. Each comparison drives its own timer-pending flag.

Software reaches both values through a single-cycle CSR port. The port has no back-pressure: a request is accepted, or faulted, in the cycle it is presented. The read data and the exception code are combinational. Writes commit at the next clock edge, and only when the access check passes.

Access goes through a layered check that can report an illegal-instruction fault or a virtual-instruction fault. While the hart runs virtualized, accesses to the supervisor compare addresses are steered to the guest copy. In 32-bit mode a compare is written as two halves, and the comparison uses the new value only once both halves have arrived. The block also holds a small writable pending register. It merges the two timer flags and a guest external-pending input into a reported pending word, and raises an interrupt request when any bit of that word is enabled.

Top module: `vstc_timer_unit`

## Requirements
- R1: While reset is asserted, both timer-pending outputs and `pend_view` are 0. After reset, both compare registers read as zero.
- R2: In 64-bit mode (`mode_32`=0), a write to a low-half address (0x14D supervisor, 0x24D guest) replaces all 64 bits. A read of that address returns all 64 bits.
- R3: In 32-bit mode, a write to a low address (0x14D/0x24D) updates bits 31:0 only, and a write to a high address (0x15D/0x25D) updates bits 63:32 only. Reads return the addressed half, zero-extended. The comparison keeps its previous value until both halves have been written, in either order. After that the half-tracking clears.
- R4: After each clock edge, `s_timer_pend` is 1 exactly when `time_now` is greater than or equal to the supervisor compare value in use, as an unsigned 64-bit comparison.
- R5: After each clock edge, `g_timer_pend` is 1 exactly when (`time_now` + `guest_delta`) mod 2^64 is greater than or equal to the guest compare value in use.
- R6: When a compare is re-armed with a value at or below the current effective time, its pending output is 1 right after the write edge. When the value is above that time, the output is 0 until the time catches up.
- R7: Access to a guest address is checked in this order, with `csr_exc` coded as 0 none, 1 illegal, 2 virtual fault:
  - `ext_en`=0 or `time_valid`=0 gives 1.
  - Otherwise, machine mode (`priv_lvl`=3) gives 0.
  - Otherwise, `m_cnt_tm`&`m_env_stce`=0 gives 1.
  - Otherwise, `h_cnt_tm`&`h_env_stce`=0 gives 2.
  - Otherwise, the result is 0.
- R8: Supervisor addresses take the same check. The hypervisor step applies to them only while `virt_on`=1. A high-half address in 64-bit mode, or any address outside the four, gives 1.
- R9: While `virt_on`=1, reads and writes of 0x14D/0x15D act on the guest compare register.
- R10: An access that faults changes no state.
- R11: A `pend_we` cycle sets `pend_q` = (`pend_q` & ~`pend_mask`) | (`pend_wval` & `pend_mask`). The write is ignored when `pend_mask` is exactly bit 6 while the guest timer flag is 1. `pend_view` = `pend_q` with bit 5 ORed with the supervisor flag, bit 6 ORed with the guest flag, and bit 10 ORed with `guest_ext_pend`.
- R12: `irq_req` is 1 exactly when (`pend_view` & `irq_en`) is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR access present this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 64 | Write data |
| priv_lvl | input | 2 | Current privilege (3 = machine) |
| virt_on | input | 1 | Hart is virtualized |
| mode_32 | input | 1 | 32-bit register mode |
| csr_rdata | output | 64 | Read data (0 on fault) |
| csr_exc | output | 2 | 0 none, 1 illegal, 2 virtual fault |
| ext_en | input | 1 | Compare extension enabled |
| time_valid | input | 1 | A time source is present |
| m_cnt_tm | input | 1 | Machine counter-enable time bit |
| m_env_stce | input | 1 | Machine environment compare-enable bit |
| h_cnt_tm | input | 1 | Hypervisor counter-enable time bit |
| h_env_stce | input | 1 | Hypervisor environment compare-enable bit |
| time_now | input | 64 | Free-running time value |
| guest_delta | input | 64 | Hypervisor time offset for the guest |
| pend_we | input | 1 | Pending-register write strobe |
| pend_mask | input | 64 | Bits to update |
| pend_wval | input | 64 | New values for masked bits |
| guest_ext_pend | input | 1 | Guest external interrupt pending |
| irq_en | input | 64 | Interrupt-enable word |
| pend_view | output | 64 | Reported pending word |
| s_timer_pend | output | 1 | Supervisor timer pending |
| g_timer_pend | output | 1 | Guest timer pending |
| irq_req | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a half-written compare in 32-bit mode: the visible register already holds a new half, while the comparison still uses the old value. The stimulus first arms a compare that is in the past, so the pending flag is 1. It then writes a single half that, taken on its own, would lie in the future. The flag must stay 1. The second half then re-arms the compare. A later pair of writes, high half first, shows that the half-tracking cleared and works in either order. A second hard case is the ignored pending write. The guest flag is driven to 1 through the compare, a bit-6-only write is issued, and then the compare is moved into the future, so the reported bit shows whether the write landed.

// File: rtl/vstc_pkg.sv
package vstc_pkg;
  typedef enum logic [1:0] {
    EXC_NONE    = 2'd0,
    EXC_ILLEGAL = 2'd1,
    EXC_VIRT    = 2'd2
  } exc_e;

  localparam logic [11:0] ADDR_S_LO = 12'h14D;
  localparam logic [11:0] ADDR_S_HI = 12'h15D;
  localparam logic [11:0] ADDR_G_LO = 12'h24D;
  localparam logic [11:0] ADDR_G_HI = 12'h25D;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  localparam int BIT_S_TIMER = 5;
  localparam int BIT_G_TIMER = 6;
  localparam int BIT_G_EXT   = 10;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/vstc_access_chk.sv
module vstc_access_chk
  import vstc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] addr,
  input  logic [1:0]  priv_lvl,
  input  logic        virt_on,
  input  logic        mode_32,
  input  logic        ext_en,
  input  logic        time_valid,
  input  logic        m_ok,
  input  logic        h_ok,
  output exc_e        exc,
  output logic        sel_guest,
  output logic        sel_hi
);
  logic is_s, is_g, known;

  assign is_s   = (addr == ADDR_S_LO) || (addr == ADDR_S_HI);
  assign is_g   = (addr == ADDR_G_LO) || (addr == ADDR_G_HI);
  assign known  = is_s || is_g;
  assign sel_hi = (addr == ADDR_S_HI) || (addr == ADDR_G_HI);
  // Supervisor addresses are steered to the guest copy while virtualized
  assign sel_guest = is_g || (is_s && virt_on);

  always_comb begin
    if (!known)                            exc = EXC_ILLEGAL;
    else if (sel_hi && !mode_32)           exc = EXC_ILLEGAL;
    else if (!ext_en || !time_valid)       exc = EXC_ILLEGAL;
    else if (priv_lvl == PRIV_MACHINE)     exc = EXC_NONE;
    else if (!m_ok)                        exc = EXC_ILLEGAL;
    else if ((is_g || virt_on) && !h_ok)   exc = EXC_VIRT;
    else                                   exc = EXC_NONE;
  end

  p_no_vfault_in_machine_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc == EXC_VIRT) |-> (priv_lvl != PRIV_MACHINE));

  p_no_vfault_without_h_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc == EXC_VIRT) |-> (!h_ok && m_ok));

  p_high_in_rv64_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi && !mode_32) |-> (exc == EXC_ILLEGAL));

  p_disabled_ext_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en || !time_valid) |-> (exc == EXC_ILLEGAL));
endmodule

// File: rtl/vstc_cmp_bank.sv
module vstc_cmp_bank #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic          half_mode,
  input  logic [TW-1:0] wdata,
  input  logic [TW-1:0] time_eff,
  output logic [TW-1:0] cmp_val,
  output logic          pend
);
  localparam int HW = TW / 2;

  logic [TW-1:0] reg_q, reg_d, arm_q, arm_d;
  logic [1:0]    mask_q, mask_d;
  logic          flag_q;

  always_comb begin
    reg_d  = reg_q;
    arm_d  = arm_q;
    mask_d = mask_q;
    if (wr_en) begin
      if (!half_mode) begin
        reg_d  = wdata;
        arm_d  = wdata;
        mask_d = 2'b00;
      end else begin
        if (wr_hi) begin
          reg_d[TW-1:HW] = wdata[HW-1:0];
          mask_d[1]      = 1'b1;
        end else begin
          reg_d[HW-1:0]  = wdata[HW-1:0];
          mask_d[0]      = 1'b1;
        end
        if (mask_d == 2'b11) begin
          arm_d  = reg_d;
          mask_d = 2'b00;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q  <= '0;
      arm_q  <= '0;
      mask_q <= 2'b00;
      flag_q <= 1'b0;
    end else begin
      reg_q  <= reg_d;
      arm_q  <= arm_d;
      mask_q <= mask_d;
      flag_q <= (time_eff >= arm_d);
    end
  end

  assign cmp_val = reg_q;
  assign pend    = flag_q;

  p_mask_never_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q != 2'b11);

  p_first_half_holds_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && half_mode && mask_q == 2'b00) |=> $stable(arm_q));

  p_past_value_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !half_mode && (wdata <= time_eff)) |=> flag_q);

  p_future_value_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !half_mode && (wdata > time_eff)) |=> !flag_q);
endmodule

// File: rtl/vstc_timer_unit.sv
module vstc_timer_unit
  import vstc_pkg::*;
#(
  parameter int TW = 64,
  parameter int PW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csr_req,
  input  logic          csr_we,
  input  logic [11:0]   csr_addr,
  input  logic [TW-1:0] csr_wdata,
  input  logic [1:0]    priv_lvl,
  input  logic          virt_on,
  input  logic          mode_32,
  output logic [TW-1:0] csr_rdata,
  output logic [1:0]    csr_exc,
  input  logic          ext_en,
  input  logic          time_valid,
  input  logic          m_cnt_tm,
  input  logic          m_env_stce,
  input  logic          h_cnt_tm,
  input  logic          h_env_stce,
  input  logic [TW-1:0] time_now,
  input  logic [TW-1:0] guest_delta,
  input  logic          pend_we,
  input  logic [PW-1:0] pend_mask,
  input  logic [PW-1:0] pend_wval,
  input  logic          guest_ext_pend,
  input  logic [PW-1:0] irq_en,
  output logic [PW-1:0] pend_view,
  output logic          s_timer_pend,
  output logic          g_timer_pend,
  output logic          irq_req
);
  localparam int HW = TW / 2;
  localparam logic [PW-1:0] G_TIMER_ONLY = PW'(1) << BIT_G_TIMER;

  exc_e          exc;
  logic          sel_guest, sel_hi, commit;
  logic [TW-1:0] bank_val  [NUM_BANKS];
  logic [TW-1:0] bank_time [NUM_BANKS];
  logic          bank_pend [NUM_BANKS];
  logic [TW-1:0] sel_val;
  logic [PW-1:0] pend_q;

  vstc_access_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (csr_addr),
    .priv_lvl   (priv_lvl),
    .virt_on    (virt_on),
    .mode_32    (mode_32),
    .ext_en     (ext_en),
    .time_valid (time_valid),
    .m_ok       (m_cnt_tm & m_env_stce),
    .h_ok       (h_cnt_tm & h_env_stce),
    .exc        (exc),
    .sel_guest  (sel_guest),
    .sel_hi     (sel_hi)
  );

  assign commit = csr_req && csr_we && (exc == EXC_NONE);

  // Bank 0 is the supervisor copy, bank 1 the guest copy (offset time base)
  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    if (gi == 0) begin : g_sup
      assign bank_time[gi] = time_now;
    end else begin : g_gst
      assign bank_time[gi] = time_now + guest_delta;
    end
    vstc_cmp_bank #(.TW(TW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (commit && (sel_guest == (gi == 1))),
      .wr_hi     (sel_hi),
      .half_mode (mode_32),
      .wdata     (csr_wdata),
      .time_eff  (bank_time[gi]),
      .cmp_val   (bank_val[gi]),
      .pend      (bank_pend[gi])
    );
  end

  assign sel_val = sel_guest ? bank_val[1] : bank_val[0];

  always_comb begin
    csr_rdata = '0;
    if (csr_req && exc == EXC_NONE) begin
      if (!mode_32)    csr_rdata = sel_val;
      else if (sel_hi) csr_rdata = {{HW{1'b0}}, sel_val[TW-1:HW]};
      else             csr_rdata = {{HW{1'b0}}, sel_val[HW-1:0]};
    end
  end
  assign csr_exc = exc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_we && !(pend_mask == G_TIMER_ONLY && bank_pend[1])) begin
      pend_q <= (pend_q & ~pend_mask) | (pend_wval & pend_mask);
    end
  end

  always_comb begin
    pend_view              = pend_q;
    pend_view[BIT_S_TIMER] = pend_q[BIT_S_TIMER] | bank_pend[0];
    pend_view[BIT_G_TIMER] = pend_q[BIT_G_TIMER] | bank_pend[1];
    pend_view[BIT_G_EXT]   = pend_q[BIT_G_EXT] | guest_ext_pend;
  end

  assign s_timer_pend = bank_pend[0];
  assign g_timer_pend = bank_pend[1];
  assign irq_req      = |(pend_view & irq_en);

  p_fault_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && exc != EXC_NONE) |=> ($stable(bank_val[0]) && $stable(bank_val[1])));

  p_gtimer_write_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_we && pend_mask == G_TIMER_ONLY && g_timer_pend) |=> $stable(pend_q));

  p_irq_needs_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_en != '0));

  p_fault_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc != EXC_NONE) |-> (csr_rdata == '0));
endmodule

// File: tb/vstc_timer_unit_tb.sv
module vstc_timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_req, csr_we, virt_on, mode_32;
  logic [11:0] csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic [1:0]  priv_lvl, csr_exc;
  logic        ext_en, time_valid, m_cnt_tm, m_env_stce, h_cnt_tm, h_env_stce;
  logic [63:0] time_now, guest_delta;
  logic        pend_we, guest_ext_pend;
  logic [63:0] pend_mask, pend_wval, irq_en, pend_view;
  logic        s_timer_pend, g_timer_pend, irq_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  vstc_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .priv_lvl(priv_lvl),
    .virt_on(virt_on), .mode_32(mode_32), .csr_rdata(csr_rdata),
    .csr_exc(csr_exc), .ext_en(ext_en), .time_valid(time_valid),
    .m_cnt_tm(m_cnt_tm), .m_env_stce(m_env_stce), .h_cnt_tm(h_cnt_tm),
    .h_env_stce(h_env_stce), .time_now(time_now), .guest_delta(guest_delta),
    .pend_we(pend_we), .pend_mask(pend_mask), .pend_wval(pend_wval),
    .guest_ext_pend(guest_ext_pend), .irq_en(irq_en), .pend_view(pend_view),
    .s_timer_pend(s_timer_pend), .g_timer_pend(g_timer_pend), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [63:0] d, output logic [1:0] e);
    @(negedge clk);
    csr_req = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
    #1 e = csr_exc;
    @(negedge clk);
    csr_req = 0; csr_we = 0;
    #1;
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [63:0] d, output logic [1:0] e);
    @(negedge clk);
    csr_req = 1; csr_we = 0; csr_addr = a;
    #1 d = csr_rdata; e = csr_exc;
    @(negedge clk);
    csr_req = 0;
    #1;
  endtask

  task automatic pend_wr(input logic [63:0] m, input logic [63:0] v);
    @(negedge clk);
    pend_we = 1; pend_mask = m; pend_wval = v;
    @(negedge clk);
    pend_we = 0;
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic [1:0] e;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 s pend in reset", {63'd0, s_timer_pend}, 64'd0);
    chk("R1 g pend in reset", {63'd0, g_timer_pend}, 64'd0);
    chk("R1 view in reset", pend_view, 64'd0);
    @(negedge clk); rst_n = 1;
    csr_rd(12'h14D, d, e); chk("R1 sup cmp zero", d, 64'd0);
    csr_rd(12'h24D, d, e); chk("R1 guest cmp zero", d, 64'd0);
  endtask

  task automatic t_rv64();
    logic [63:0] d; logic [1:0] e;
    time_now = 64'd1000;
    csr_wr(12'h14D, 64'h1234_5678_9ABC_DEF0, e);
    csr_rd(12'h14D, d, e);
    chk("R2 full 64-bit write", d, 64'h1234_5678_9ABC_DEF0);
    chk("R6 future clears", {63'd0, s_timer_pend}, 64'd0);
    csr_wr(12'h14D, 64'd500, e);
    chk("R6 past sets at once", {63'd0, s_timer_pend}, 64'd1);
    csr_wr(12'h14D, 64'd2000, e);
    chk("R4 not reached", {63'd0, s_timer_pend}, 64'd0);
    @(negedge clk); time_now = 64'd1999; tick();
    chk("R4 one below", {63'd0, s_timer_pend}, 64'd0);
    @(negedge clk); time_now = 64'd2000; tick();
    chk("R4 equal reaches", {63'd0, s_timer_pend}, 64'd1);
  endtask

  task automatic t_split();
    logic [63:0] d; logic [1:0] e;
    mode_32 = 1;
    csr_wr(12'h14D, 64'hFFFF_FFFF, e);
    chk("R3 one half keeps old arm", {63'd0, s_timer_pend}, 64'd1);
    csr_rd(12'h14D, d, e); chk("R3 low read", d, 64'hFFFF_FFFF);
    csr_rd(12'h15D, d, e); chk("R3 high read", d, 64'd0);
    csr_wr(12'h15D, 64'h10, e);
    chk("R3 both halves re-arm", {63'd0, s_timer_pend}, 64'd0);
    csr_wr(12'h15D, 64'h0, e);
    chk("R3 high alone no re-arm", {63'd0, s_timer_pend}, 64'd0);
    csr_wr(12'h14D, 64'd5, e);
    chk("R3 high-then-low re-arms", {63'd0, s_timer_pend}, 64'd1);
    csr_rd(12'h15D, d, e); chk("R3 high after pair", d, 64'd0);
    csr_rd(12'h14D, d, e); chk("R3 low after pair", d, 64'd5);
    mode_32 = 0;
  endtask

  task automatic t_guest();
    logic [1:0] e;
    time_now = 64'd100; guest_delta = 64'd50;
    csr_wr(12'h24D, 64'd160, e);
    chk("R5 guest below", {63'd0, g_timer_pend}, 64'd0);
    @(negedge clk); guest_delta = 64'd60; tick();
    chk("R5 delta reaches", {63'd0, g_timer_pend}, 64'd1);
    @(negedge clk); guest_delta = 64'hFFFF_FFFF_FFFF_FFCE; tick();
    chk("R5 wrapping delta", {63'd0, g_timer_pend}, 64'd0);
    @(negedge clk); time_now = 64'd210; tick();
    chk("R5 wrapped sum reaches", {63'd0, g_timer_pend}, 64'd1);
    chk("R4 sup uses raw time", {63'd0, s_timer_pend}, 64'd1);
  endtask

  task automatic t_access();
    logic [63:0] d; logic [1:0] e;
    priv_lvl = 2'b01; ext_en = 0;
    csr_rd(12'h24D, d, e); chk("R7 ext off", {62'd0, e}, 64'd1);
    ext_en = 1; time_valid = 0;
    csr_rd(12'h24D, d, e); chk("R7 no time source", {62'd0, e}, 64'd1);
    time_valid = 1; m_env_stce = 0; h_cnt_tm = 0; priv_lvl = 2'b11;
    csr_rd(12'h24D, d, e); chk("R7 machine allowed", {62'd0, e}, 64'd0);
    priv_lvl = 2'b01;
    csr_rd(12'h24D, d, e); chk("R7 machine gate first", {62'd0, e}, 64'd1);
    m_env_stce = 1;
    csr_rd(12'h24D, d, e); chk("R7 hyp gate vfault", {62'd0, e}, 64'd2);
    csr_rd(12'h14D, d, e); chk("R8 sup skips hyp gate", {62'd0, e}, 64'd0);
    h_cnt_tm = 1;
    csr_rd(12'h24D, d, e); chk("R7 all open", {62'd0, e}, 64'd0);
    csr_rd(12'h25D, d, e); chk("R8 high in rv64", {62'd0, e}, 64'd1);
    csr_rd(12'h123, d, e); chk("R8 unknown addr", {62'd0, e}, 64'd1);
    priv_lvl = 2'b11;
  endtask

  task automatic t_redirect();
    logic [63:0] d; logic [1:0] e;
    virt_on = 1; priv_lvl = 2'b01;
    csr_rd(12'h14D, d, e); chk("R9 virt read guest", d, 64'd160);
    csr_wr(12'h14D, 64'd999, e);
    chk("R9 virt write guest pend", {63'd0, g_timer_pend}, 64'd0);
    h_env_stce = 0;
    csr_rd(12'h14D, d, e); chk("R8 virt sup vfault", {62'd0, e}, 64'd2);
    h_env_stce = 1; virt_on = 0; priv_lvl = 2'b11;
    csr_rd(12'h14D, d, e); chk("R9 sup untouched", d, 64'd5);
    csr_rd(12'h24D, d, e); chk("R9 guest got write", d, 64'd999);
  endtask

  task automatic t_fault();
    logic [63:0] d; logic [1:0] e;
    priv_lvl = 2'b01; m_cnt_tm = 0;
    csr_wr(12'h24D, 64'd1, e);
    chk("R10 write faulted", {62'd0, e}, 64'd1);
    m_cnt_tm = 1; priv_lvl = 2'b11;
    csr_rd(12'h24D, d, e); chk("R10 guest unchanged", d, 64'd999);
    chk("R10 pend unchanged", {63'd0, g_timer_pend}, 64'd0);
  endtask

  task automatic t_pending();
    logic [1:0] e;
    pend_wr(64'h40, 64'h40);
    chk("R11 bit6 write lands", {63'd0, pend_view[6]}, 64'd1);
    pend_wr(64'h40, 64'h0);
    chk("R11 bit6 cleared", {63'd0, pend_view[6]}, 64'd0);
    csr_wr(12'h24D, 64'd0, e);
    chk("R11 guest flag up", {63'd0, pend_view[6]}, 64'd1);
    pend_wr(64'h40, 64'h40);
    csr_wr(12'h24D, 64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R11 bit6-only write ignored", {63'd0, pend_view[6]}, 64'd0);
    csr_wr(12'h24D, 64'd0, e);
    pend_wr(64'h48, 64'h48);
    csr_wr(12'h24D, 64'hFFFF_FFFF_FFFF_FFFF, e);
    chk("R11 wider mask lands", pend_view, 64'h68);
  endtask

  task automatic t_irq();
    @(negedge clk); irq_en = 64'd0; #1;
    chk("R12 nothing enabled", {63'd0, irq_req}, 64'd0);
    @(negedge clk); irq_en = 64'h8; #1;
    chk("R12 soft bit enabled", {63'd0, irq_req}, 64'd1);
    pend_wr(64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    chk("R12 soft bit cleared", {63'd0, irq_req}, 64'd0);
    chk("R11 view sup timer only", pend_view, 64'h20);
    @(negedge clk); irq_en = 64'h20; #1;
    chk("R12 sup timer enabled", {63'd0, irq_req}, 64'd1);
    @(negedge clk); irq_en = 64'h400; guest_ext_pend = 1; #1;
    chk("R12 guest ext enabled", {63'd0, irq_req}, 64'd1);
    chk("R11 guest ext in view", pend_view, 64'h420);
  endtask

  initial begin
    rst_n = 0; csr_req = 0; csr_we = 0; csr_addr = '0; csr_wdata = '0;
    priv_lvl = 2'b11; virt_on = 0; mode_32 = 0;
    ext_en = 1; time_valid = 1; m_cnt_tm = 1; m_env_stce = 1; h_cnt_tm = 1; h_env_stce = 1;
    time_now = '0; guest_delta = '0; pend_we = 0; pend_mask = '0; pend_wval = '0;
    guest_ext_pend = 0; irq_en = '0;
    t_reset();
    t_rv64();
    t_split();
    t_guest();
    t_access();
    t_redirect();
    t_fault();
    t_pending();
    t_irq();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule